// File: doc/BRIEF.md
# Single-precision floating-point adder/subtractor

This block adds or subtracts two IEEE-754 binary32 operands and returns the result rounded to nearest, ties to even. A select input chooses subtraction. Subtraction is addition with the sign of the second operand flipped. The block also reports the invalid-operation, overflow, underflow and inexact flags. The divide-by-zero output is present for a uniform flag bus and is always low.

The datapath is one pass. It classifies both operands and orders them by magnitude. It aligns the smaller operand by the exponent difference, keeping guard, round and sticky bits. It then adds or subtracts the significands and normalises with a leading-zero count clamped at the subnormal boundary. Rounding is a single increment of the packed exponent and fraction. NaN, infinity and zero cases are resolved beside the datapath. By default the result and flags are registered, one clock after the operands.

Top module: `fpadd_core`

## Requirements
- R1: The operation is an effective subtraction when `sub_sel`=0 and the operand signs differ, or when `sub_sel`=1 and the signs match. Otherwise it is an effective addition. The sign bit is bit 31.
- R2: For finite operands, `sum_o` is the exact sum rounded to nearest, ties to even. The alignment sticky bit is the OR of every significand bit shifted out.
- R3: Two infinities under an effective subtraction set `nv_o` and give the quiet NaN 0x7FC00000.
- R4: A NaN operand (exponent all ones, fraction nonzero) is signalling when fraction bit 22 is 0. Any signalling NaN operand sets `nv_o`. Any NaN operand gives 0x7FC00000. Quiet NaNs alone leave `nv_o` low.
- R5: When the rounded magnitude does not fit below exponent 255, `of_o` and `nx_o` are set and the result is an infinity with the sign of the larger operand. For example, 0x7F400000 + 0x7F400000 gives 0x7F800000.
- R6: `uf_o` and `dz_o` are never set. A subnormal result is always exact, so `nx_o` is low with it.
- R7: Two finite nonzero operands whose exponent fields differ by more than 24 report `nx_o` or `of_o`.
- R8: Operands with equal exponents and the low 8 fraction bits zero give an exact result (`nx_o`=0) unless `of_o` is set.
- R9: An infinity result that is not an overflow takes the sign of the infinite operand and has `nx_o`=0.
- R10: An exact zero sum is +0, except that two zeros with the same effective sign give a zero of that sign.
- R11: With `REG_OUT`=1, outputs change one clock after the operands. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| sub_sel | input | 1 | 1 = subtract `op_b` from `op_a` |
| sum_o | output | 32 | Rounded result, binary32 |
| nv_o | output | 1 | Invalid operation |
| dz_o | output | 1 | Divide by zero, always 0 |
| of_o | output | 1 | Overflow |
| uf_o | output | 1 | Underflow, always 0 |
| nx_o | output | 1 | Inexact |

## Verification
The bench covers the following corner cases and the failure each one would expose:
- Exact ties at half an ulp: a design that rounds them up instead of to even would return an odd fraction.
- Operands shifted wholly into the sticky bit: a design that drops the sticky bit would report an exact result or lose the final decrement after a subtraction.
- Massive cancellation needing a 23-place left shift: a wrong leading-zero count gives a wrong exponent.
- Subnormal sums and differences across the normal boundary: a design without the clamp would emit a normalised, wrong value.
- Carry out of rounding into the exponent at the largest finite value: this must become an overflow infinity.
- Sign rules for zero results and infinity clashes: these catch a design that copies a sign blindly.
- Signalling versus quiet NaN inputs: these catch one that misreads fraction bit 22.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;
   // operand category after decode; zero is a finite value with a null significand
   typedef enum logic [1:0] {
      OPK_FINITE = 2'd0,
      OPK_INF    = 2'd1,
      OPK_QNAN   = 2'd2,
      OPK_SNAN   = 2'd3
   } opkind_e;
endpackage

// File: rtl/fpadd_classify.sv
`timescale 1ns/1ps
module fpadd_classify
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   output opkind_e               kind_o,
   output logic                  sign_o,
   output logic [EXP_W-1:0]      exp_o,
   output logic [FRAC_W:0]       sig_o
);
   logic [EXP_W-1:0]  efld;
   logic [FRAC_W-1:0] frac;
   logic              e_max, e_zero;

   assign efld   = word_i[EXP_W+FRAC_W-1:FRAC_W];
   assign frac   = word_i[FRAC_W-1:0];
   assign e_max  = &efld;
   assign e_zero = ~|efld;
   assign sign_o = word_i[EXP_W+FRAC_W];
   // subnormals share the exponent of the smallest normal, hidden bit cleared
   assign exp_o  = e_zero ? EXP_W'(1) : efld;
   assign sig_o  = {~e_zero, frac};

   always_comb begin
      if (!e_max)                kind_o = OPK_FINITE;
      else if (frac == '0)       kind_o = OPK_INF;
      else if (frac[FRAC_W-1])   kind_o = OPK_QNAN;
      else                       kind_o = OPK_SNAN;
   end
endmodule

// File: rtl/fpadd_align_sum.sv
`timescale 1ns/1ps
module fpadd_align_sum #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SW    = FRAC_W + 1,
   localparam int SUMW  = SW + 4
) (
   input  logic             sign_a_i,
   input  logic [EXP_W-1:0] exp_a_i,
   input  logic [SW-1:0]    sig_a_i,
   input  logic             sign_b_i,   // already the effective sign
   input  logic [EXP_W-1:0] exp_b_i,
   input  logic [SW-1:0]    sig_b_i,
   output logic             big_sign_o,
   output logic [EXP_W-1:0] big_exp_o,
   output logic [SUMW-1:0]  sum_o
);
   localparam int WIDE = 2*SW + 2;

   logic             a_ge, eff_sub;
   logic [EXP_W-1:0] exp_y, diff;
   logic [SW-1:0]    sig_x, sig_y;
   logic [WIDE-1:0]  y_wide, y_sh;
   logic [SW+2:0]    x_ext, y_ext;
   int unsigned      shamt;

   assign a_ge       = {exp_a_i, sig_a_i} >= {exp_b_i, sig_b_i};
   assign eff_sub    = sign_a_i ^ sign_b_i;
   assign big_sign_o = a_ge ? sign_a_i : sign_b_i;
   assign big_exp_o  = a_ge ? exp_a_i  : exp_b_i;
   assign exp_y      = a_ge ? exp_b_i  : exp_a_i;
   assign sig_x      = a_ge ? sig_a_i  : sig_b_i;
   assign sig_y      = a_ge ? sig_b_i  : sig_a_i;
   assign diff       = big_exp_o - exp_y;

   // beyond SW+2 places every bit of the smaller significand lands in sticky
   assign shamt  = (int'(diff) > SW + 2) ? SW + 2 : int'(diff);
   assign y_wide = {sig_y, {(SW+2){1'b0}}};
   assign y_sh   = y_wide >> shamt;
   assign y_ext  = {y_sh[WIDE-1:SW], |y_sh[SW-1:0]};
   assign x_ext  = {sig_x, 3'b000};

   assign sum_o = eff_sub ? ({1'b0, x_ext} - {1'b0, y_ext})
                          : ({1'b0, x_ext} + {1'b0, y_ext});
endmodule

// File: rtl/fpadd_norm_round.sv
`timescale 1ns/1ps
module fpadd_norm_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SW    = FRAC_W + 1,
   localparam int NW    = SW + 3,
   localparam int SUMW  = SW + 4
) (
   input  logic [SUMW-1:0]         sum_i,
   input  logic [EXP_W-1:0]        exp_i,
   output logic [EXP_W+FRAC_W-1:0] mag_o,
   output logic                    inexact_o,
   output logic                    ovf_o
);
   localparam int EW1  = EXP_W + 1;
   localparam int PKW  = EXP_W + FRAC_W + 1;
   localparam int EMAX = (1 << EXP_W) - 1;

   logic [EXP_W:0]   lz, lim, sh, e, efield;
   logic [NW-1:0]    n;
   logic             g, r, st, rup;
   logic [PKW-1:0]   pk;

   // leading-zero count over the non-carry part of the sum
   always_comb begin
      lz = EW1'(NW);
      for (int i = 0; i < NW; i++)
         if (sum_i[i]) lz = EW1'(NW - 1 - i);
   end

   assign lim = {1'b0, exp_i} - EW1'(1);

   always_comb begin
      sh = '0;
      if (sum_i[NW]) begin
         n = {sum_i[NW:2], sum_i[1] | sum_i[0]};
         e = {1'b0, exp_i} + EW1'(1);
      end else begin
         // the clamp stops normalisation at the subnormal boundary
         sh = (lz > lim) ? lim : lz;
         n  = sum_i[NW-1:0] << sh;
         e  = {1'b0, exp_i} - sh;
      end
   end

   assign efield = n[NW-1] ? e : '0;
   assign g      = n[2];
   assign r      = n[1];
   assign st     = n[0];
   assign rup    = g & (r | st | n[3]);
   // one increment covers fraction carry into exponent and subnormal to normal
   assign pk     = {efield, n[NW-2:3]} + PKW'(rup);
   assign ovf_o  = pk[PKW-1:FRAC_W] >= EW1'(EMAX);
   assign inexact_o = g | r | st | ovf_o;
   assign mag_o  = ovf_o ? {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} : pk[PKW-2:0];
endmodule

// File: rtl/fpadd_core.sv
`timescale 1ns/1ps
module fpadd_core
   import fpadd_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit REG_OUT = 1'b1,
   localparam int TW     = 1 + EXP_W + FRAC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] op_a,
   input  logic [TW-1:0] op_b,
   input  logic          sub_sel,
   output logic [TW-1:0] sum_o,
   output logic          nv_o,
   output logic          dz_o,
   output logic          of_o,
   output logic          uf_o,
   output logic          nx_o
);
   localparam int SW   = FRAC_W + 1;
   localparam int SUMW = SW + 4;
   localparam logic [TW-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   if (EXP_W < 4 || EXP_W > 15) begin : g_bad_exp
      $error("fpadd_core: EXP_W out of range");
   end
   if (FRAC_W < 3 || $clog2(SW + 4) > EXP_W) begin : g_bad_frac
      $error("fpadd_core: FRAC_W out of range for EXP_W");
   end

   logic [TW-1:0]    word [2];
   opkind_e          kind [2];
   logic             sgn  [2];
   logic [EXP_W-1:0] ex   [2];
   logic [SW-1:0]    sg   [2];

   assign word[0] = op_a;
   assign word[1] = op_b;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fpadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .word_i (word[k]),
         .kind_o (kind[k]),
         .sign_o (sgn[k]),
         .exp_o  (ex[k]),
         .sig_o  (sg[k])
      );
   end

   logic                    sb_eff, big_sign, nx_dp, of_dp;
   logic [EXP_W-1:0]        big_exp;
   logic [SUMW-1:0]         sum_raw;
   logic [EXP_W+FRAC_W-1:0] mag;

   assign sb_eff = sgn[1] ^ sub_sel;

   fpadd_align_sum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .sign_a_i   (sgn[0]),
      .exp_a_i    (ex[0]),
      .sig_a_i    (sg[0]),
      .sign_b_i   (sb_eff),
      .exp_b_i    (ex[1]),
      .sig_b_i    (sg[1]),
      .big_sign_o (big_sign),
      .big_exp_o  (big_exp),
      .sum_o      (sum_raw)
   );

   fpadd_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .sum_i     (sum_raw),
      .exp_i     (big_exp),
      .mag_o     (mag),
      .inexact_o (nx_dp),
      .ovf_o     (of_dp)
   );

   logic          a_nan, b_nan, any_snan, inf_clash;
   logic [TW-1:0] res_c;
   logic          nv_c, of_c, nx_c;

   assign a_nan     = kind[0] == OPK_QNAN || kind[0] == OPK_SNAN;
   assign b_nan     = kind[1] == OPK_QNAN || kind[1] == OPK_SNAN;
   assign any_snan  = kind[0] == OPK_SNAN || kind[1] == OPK_SNAN;
   assign inf_clash = kind[0] == OPK_INF && kind[1] == OPK_INF && (sgn[0] ^ sb_eff);

   always_comb begin
      nv_c = 1'b0;
      of_c = 1'b0;
      nx_c = 1'b0;
      if (a_nan || b_nan || inf_clash) begin
         res_c = QNAN;
         nv_c  = any_snan || inf_clash;
      end else if (kind[0] == OPK_INF) begin
         res_c = {sgn[0], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (kind[1] == OPK_INF) begin
         res_c = {sb_eff, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (sum_raw == '0) begin
         res_c = {sgn[0] & sb_eff, {(TW-1){1'b0}}};
      end else begin
         res_c = {big_sign, mag};
         of_c  = of_dp;
         nx_c  = nx_dp;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sum_o <= '0;
            nv_o  <= 1'b0;
            of_o  <= 1'b0;
            nx_o  <= 1'b0;
         end else begin
            sum_o <= res_c;
            nv_o  <= nv_c;
            of_o  <= of_c;
            nx_o  <= nx_c;
         end
      end
   end else begin : g_comb
      assign sum_o = res_c;
      assign nv_o  = nv_c;
      assign of_o  = of_c;
      assign nx_o  = nx_c;
   end

   assign dz_o = 1'b0;
   assign uf_o = 1'b0;

   logic o_inf, o_sub;
   assign o_inf = &sum_o[TW-2:FRAC_W] && sum_o[FRAC_W-1:0] == '0;
   assign o_sub = sum_o[TW-2:FRAC_W] == '0 && sum_o[FRAC_W-1:0] != '0;

   a_r5_of_implies_nx: assert property (@(posedge clk) disable iff (!rst_n)
      of_o |-> nx_o);
   a_r5_of_gives_inf: assert property (@(posedge clk) disable iff (!rst_n)
      of_o |-> o_inf);
   a_r3_nv_gives_qnan: assert property (@(posedge clk) disable iff (!rst_n)
      nv_o |-> sum_o == QNAN);
   a_r9_exact_inf: assert property (@(posedge clk) disable iff (!rst_n)
      (o_inf && !of_o) |-> !nx_o);
   a_r6_subnormal_exact: assert property (@(posedge clk) disable iff (!rst_n)
      o_sub |-> !nx_o);
endmodule

// File: tb/fpadd_core_tb_top.sv
`timescale 1ns/1ps
module fpadd_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        sub_sel = 1'b0;
   logic [31:0] sum_o;
   logic        nv_o, dz_o, of_o, uf_o, nx_o;

   int n_run = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   fpadd_core dut_i (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
      .sum_o(sum_o), .nv_o(nv_o), .dz_o(dz_o), .of_o(of_o), .uf_o(uf_o), .nx_o(nx_o)
   );

   // {tag, a, b, sub, result, flags{nv,dz,of,uf,nx}}
   localparam int NV = 34;
   localparam logic [105:0] VEC [NV] = '{
      {4'd1,  32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 5'b00000}, // R1
      {4'd10, 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 5'b00000}, // R10
      {4'd1,  32'h3F800000, 32'hBF800000, 1'b0, 32'h00000000, 5'b00000}, // R1
      {4'd1,  32'h40400000, 32'hBF800000, 1'b1, 32'h40800000, 5'b00000}, // R1
      {4'd2,  32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 5'b00001}, // R2 tie to even
      {4'd2,  32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 5'b00001}, // R2 above half
      {4'd7,  32'h3F800000, 32'h33000000, 1'b0, 32'h3F800000, 5'b00001}, // R7
      {4'd5,  32'h7F400000, 32'h7F400000, 1'b0, 32'h7F800000, 5'b00101}, // R5
      {4'd5,  32'hFF400000, 32'h7F400000, 1'b1, 32'hFF800000, 5'b00101}, // R5
      {4'd3,  32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 5'b10000}, // R3
      {4'd3,  32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 5'b10000}, // R3
      {4'd9,  32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 5'b00000}, // R9
      {4'd9,  32'hFF800000, 32'h3F800000, 1'b0, 32'hFF800000, 5'b00000}, // R9
      {4'd9,  32'h3F800000, 32'hFF800000, 1'b1, 32'h7F800000, 5'b00000}, // R9
      {4'd4,  32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, 5'b10000}, // R4
      {4'd4,  32'h3F800000, 32'hFFA00000, 1'b0, 32'h7FC00000, 5'b10000}, // R4
      {4'd4,  32'h7FC00000, 32'h7FC00000, 1'b0, 32'h7FC00000, 5'b00000}, // R4
      {4'd4,  32'h7FC12345, 32'h3F800000, 1'b1, 32'h7FC00000, 5'b00000}, // R4
      {4'd4,  32'h7FC00000, 32'h7F800001, 1'b0, 32'h7FC00000, 5'b10000}, // R4
      {4'd6,  32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 5'b00000}, // R6
      {4'd6,  32'h00400000, 32'h00400000, 1'b0, 32'h00800000, 5'b00000}, // R6
      {4'd6,  32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, 5'b00000}, // R6
      {4'd10, 32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 5'b00000}, // R10
      {4'd10, 32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 5'b00000}, // R10
      {4'd10, 32'h80000000, 32'h00000000, 1'b0, 32'h00000000, 5'b00000}, // R10
      {4'd8,  32'h3FC00000, 32'h3FA00000, 1'b0, 32'h40300000, 5'b00000}, // R8
      {4'd2,  32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 5'b00000}, // R2 cancellation
      {4'd2,  32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 5'b00001}, // R2 carry to exponent
      {4'd5,  32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 5'b00101}, // R5 rounding overflow
      {4'd2,  32'h3F800000, 32'h33800000, 1'b1, 32'h3F7FFFFF, 5'b00000}, // R2
      {4'd7,  32'h3F800000, 32'hB2800000, 1'b0, 32'h3F800000, 5'b00001}, // R7 sticky subtraction
      {4'd1,  32'h40000000, 32'h3F800000, 1'b1, 32'h3F800000, 5'b00000}, // R1
      {4'd2,  32'h33800000, 32'h3F800000, 1'b0, 32'h3F800000, 5'b00001}, // R2 swapped order
      {4'd1,  32'hC0000000, 32'h3F800000, 1'b0, 32'hBF800000, 5'b00000}  // R1
   };

   task automatic check(input int tag, input logic [36:0] got, input logic [36:0] exp);
      n_run++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d: got %h flags %b, expected %h flags %b",
                  tag, got[36:5], got[4:0], exp[36:5], exp[4:0]);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      // R11: outputs held at zero while reset is asserted
      op_a = 32'h7F400000; op_b = 32'h7F400000;
      repeat (3) @(negedge clk);
      check(11, {sum_o, nv_o, dz_o, of_o, uf_o, nx_o}, 37'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_a    = VEC[i][101:70];
         op_b    = VEC[i][69:38];
         sub_sel = VEC[i][37];
         @(negedge clk);
         check(int'(VEC[i][105:102]), {sum_o, nv_o, dz_o, of_o, uf_o, nx_o},
               {VEC[i][36:5], VEC[i][4:0]});
      end

      // R11: one-clock latency, old value visible until the edge
      op_a = 32'h3F800000; op_b = 32'h3F800000; sub_sel = 1'b0;
      @(negedge clk);
      op_a = 32'h40400000; op_b = 32'h3F800000;
      #2 check(11, {sum_o, nv_o, dz_o, of_o, uf_o, nx_o}, {32'h40000000, 5'b00000});
      @(negedge clk);
      check(11, {sum_o, nv_o, dz_o, of_o, uf_o, nx_o}, {32'h40800000, 5'b00000});

      // R11: synchronous reset clears a loaded result
      rst_n = 1'b0;
      @(negedge clk);
      check(11, {sum_o, nv_o, dz_o, of_o, uf_o, nx_o}, 37'd0);
      rst_n = 1'b1;

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule